// File: doc/BRIEF.md
# SPI Control and Status Register Bank

This block is an SPI slave register bank for a two-axis antenna pedestal interface. A microcontroller uses it to write the control word, the encoder sampling period and the two zero offsets. It uses the same bank to read the live azimuth and elevation angles and a status word. The status word collects the drive digital outputs, two optocoupler inputs and six sticky error flags.

The control word also sets the routing of the on-board actuators. Each relay and each brake driver is driven either from a control bit or from a digital output of its own drive. A second function of the control word is error handling: the sticky errors can be cleared by hand, or cleared automatically when an axis angle passes through zero.

The SPI pins are sampled in the system clock domain through synchronizers. A frame has 8 command bits followed by 16 data bits, in SPI mode 0. Read and write share an address space, but at some addresses the two directions reach different registers.

Top module: `axis_regs_spi`

## Requirements
- R1: After reset the control word is 0x0000, the sample period output is 1450, and both offset outputs are 0.
- R2: A frame is 24 bits, MSB first, in SPI mode 0. Command bit 7 = 1 marks a write and command bits 6..0 hold the address. On the rising edge of chip select a write updates the target: address 0 the control word, 1 the sample period, 2 the azimuth offset, 3 the elevation offset.
- R3: A write frame with any bit count other than 24 changes no register.
- R4: Reading address 0 returns the control word, address 2 the azimuth angle input and address 3 the elevation angle input. The 16 data bits appear on MISO during the data phase, MSB first, each valid before the SCLK rising edge that carries it.
- R5: Reading address 1 returns status, not the sample period. The status fields are:
  - bits 15 and 14: optocoupler inputs 1 and 0;
  - bits 13..10: elevation drive outputs 4..1;
  - bits 9..6: azimuth drive outputs 4..1;
  - bits 5/4/3: elevation conversion, encoder and brake errors;
  - bits 2/1/0: the same three errors for azimuth.
- R6: A single-cycle pulse on any error input sets its status bit, and the bit stays set.
- R7: While control bit 8 is 1, the error flags are cleared. After bit 8 is written back to 0, new error pulses latch again.
- R8: While control bit 9 is 1, the three error flags of an axis clear whenever that axis angle input is zero. The flags of the other axis are untouched.
- R9: With control bit 2 = 1, relay 0 follows control bit 14 and relay 1 follows control bit 15. With bit 2 = 0, relay 0 follows azimuth drive output 2 and relay 1 follows elevation drive output 2.
- R10: With control bit 4 = 1, both brake outputs follow control bit 3. With bit 4 = 0, brake 0 follows azimuth drive output 1 and brake 1 follows elevation drive output 1.
- R11: Control bits 7..5 drive the three shared drive digital inputs 7..5. Control bit 11 sets the azimuth count direction and bit 13 sets the elevation count direction.
- R12: A write to an address above 3 changes no register, and a read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_sclk | input | 1 | SPI serial clock |
| spi_mosi | input | 1 | SPI data in |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_miso | output | 1 | SPI data out |
| az_angle | input | 16 | Corrected azimuth angle |
| el_angle | input | 16 | Corrected elevation angle |
| az_err | input | 3 | Azimuth error events {conversion, encoder, brake} |
| el_err | input | 3 | Elevation error events {conversion, encoder, brake} |
| az_dout | input | 4 | Azimuth drive digital outputs 4..1 |
| el_dout | input | 4 | Elevation drive digital outputs 4..1 |
| opto | input | 2 | Optocoupler inputs |
| sample_period | output | 16 | Encoder sampling interval |
| az_offset | output | 16 | Azimuth zero offset |
| el_offset | output | 16 | Elevation zero offset |
| az_ccw | output | 1 | Azimuth count direction |
| el_ccw | output | 1 | Elevation count direction |
| drv_din | output | 3 | Shared drive digital inputs 7..5 |
| relay | output | 2 | Relay drives {elevation, azimuth} |
| brake | output | 2 | Brake driver enables {elevation, azimuth} |

## Verification
The bench sends frames of 23 and 25 bits to check that truncated or overlong frames are dropped. A design that committed on bit count alone, or on the last byte, would load a corrupted sample period. It also reads address 1 after writing address 1, which catches a bank that folds the two directions into one register. Single-cycle error pulses check the sticky latch, and a design that showed the live input would read zero. Autoclear is tested with only one axis at zero, so a design that cleared both axes, or ignored the angle, would report the wrong flags.

// File: rtl/axis_regs_spi.sv
module axis_regs_spi #(
  parameter int W = 16,
  parameter int SAMPLE_RST = 1450
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         spi_sclk,
  input  logic         spi_mosi,
  input  logic         spi_cs_n,
  output logic         spi_miso,
  input  logic [W-1:0] az_angle,
  input  logic [W-1:0] el_angle,
  input  logic [2:0]   az_err,
  input  logic [2:0]   el_err,
  input  logic [3:0]   az_dout,
  input  logic [3:0]   el_dout,
  input  logic [1:0]   opto,
  output logic [W-1:0] sample_period,
  output logic [W-1:0] az_offset,
  output logic [W-1:0] el_offset,
  output logic         az_ccw,
  output logic         el_ccw,
  output logic [2:0]   drv_din,
  output logic [1:0]   relay,
  output logic [1:0]   brake
);
  localparam int FRAME = 8 + W;
  localparam int CW = $clog2(FRAME + 2);
  localparam logic [CW-1:0] CMAX = '1;

  logic [2:0] sclk_s, cs_s;
  logic [1:0] mosi_s;
  logic sclk_rise, sclk_fall, cs_rise, cs_act;
  logic [CW-1:0] bit_cnt;
  logic [FRAME-1:0] rx_sr;
  logic [W-1:0] tx_sr, ctrl_q, rd_word, status;
  logic [6:0] rd_addr;
  logic [5:0] err_q;
  logic clr_az, clr_el;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_s <= '0; cs_s <= '1; mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], spi_sclk};
      cs_s   <= {cs_s[1:0], spi_cs_n};
      mosi_s <= {mosi_s[0], spi_mosi};
    end

  assign sclk_rise = sclk_s[1] & ~sclk_s[2];
  assign sclk_fall = ~sclk_s[1] & sclk_s[2];
  assign cs_act    = ~cs_s[1];
  assign cs_rise   = cs_s[1] & ~cs_s[2];
  assign rd_addr   = {rx_sr[5:0], mosi_s[1]};

  assign status = {opto[1], opto[0], el_dout, az_dout, err_q[5:3], err_q[2:0]};

  always_comb
    case (rd_addr)
      7'd0:    rd_word = ctrl_q;
      7'd1:    rd_word = status;
      7'd2:    rd_word = az_angle;
      7'd3:    rd_word = el_angle;
      default: rd_word = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0; rx_sr <= '0; tx_sr <= '0;
    end else if (!cs_act) begin
      bit_cnt <= '0; tx_sr <= '0;
    end else begin
      if (sclk_rise) begin
        rx_sr <= {rx_sr[FRAME-2:0], mosi_s[1]};
        if (bit_cnt != CMAX) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CW'(7)) tx_sr <= rd_word;
      end else if (sclk_fall && bit_cnt > CW'(8)) begin
        tx_sr <= {tx_sr[W-2:0], 1'b0};
      end
    end

  assign spi_miso = cs_act & tx_sr[W-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q <= '0; sample_period <= W'(SAMPLE_RST);
      az_offset <= '0; el_offset <= '0;
    end else if (cs_rise && bit_cnt == CW'(FRAME) && rx_sr[FRAME-1]) begin
      case (rx_sr[FRAME-2:W])
        7'd0: ctrl_q        <= rx_sr[W-1:0];
        7'd1: sample_period <= rx_sr[W-1:0];
        7'd2: az_offset     <= rx_sr[W-1:0];
        7'd3: el_offset     <= rx_sr[W-1:0];
        default: ;
      endcase
    end

  assign clr_az = ctrl_q[8] | (ctrl_q[9] & (az_angle == '0));
  assign clr_el = ctrl_q[8] | (ctrl_q[9] & (el_angle == '0));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) err_q <= '0;
    else begin
      err_q[2:0] <= (err_q[2:0] & ~{3{clr_az}}) | az_err;
      err_q[5:3] <= (err_q[5:3] & ~{3{clr_el}}) | el_err;
    end

  assign relay   = ctrl_q[2] ? ctrl_q[15:14] : {el_dout[1], az_dout[1]};
  assign brake   = ctrl_q[4] ? {2{ctrl_q[3]}} : {el_dout[0], az_dout[0]};
  assign drv_din = ctrl_q[7:5];
  assign az_ccw  = ctrl_q[11];
  assign el_ccw  = ctrl_q[13];
endmodule

// File: rtl/axis_regs_spi_chk.sv
module axis_regs_spi_chk #(parameter int W = 16) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_rise,
  input logic [W-1:0] ctrl_q,
  input logic [W-1:0] sample_period,
  input logic [W-1:0] az_offset,
  input logic [W-1:0] el_offset,
  input logic [2:0]   az_err,
  input logic [2:0]   el_err,
  input logic [5:0]   err_q,
  input logic         clr_az
);
  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> ($stable(sample_period) && $stable(az_offset) && $stable(el_offset)));
  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(ctrl_q));
  // R6
  az_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|az_err) |=> ((err_q[2:0] & $past(az_err)) == $past(az_err)));
  // R6
  el_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|el_err) |=> ((err_q[5:3] & $past(el_err)) == $past(el_err)));
  // R6
  az_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_az |=> ((err_q[2:0] & $past(err_q[2:0])) == $past(err_q[2:0])));
endmodule

bind axis_regs_spi axis_regs_spi_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .ctrl_q(ctrl_q),
  .sample_period(sample_period), .az_offset(az_offset), .el_offset(el_offset),
  .az_err(az_err), .el_err(el_err), .err_q(err_q), .clr_az(clr_az)
);

// File: tb/axis_regs_spi_test.sv
`timescale 1ns/1ps
module axis_regs_spi_test;
  localparam int HALF = 8;

  logic clk = 0, rst_n = 0;
  logic spi_sclk = 0, spi_mosi = 0, spi_cs_n = 1, spi_miso;
  logic [15:0] az_angle = 16'h0101, el_angle = 16'h0202;
  logic [2:0] az_err = 0, el_err = 0;
  logic [3:0] az_dout = 0, el_dout = 0;
  logic [1:0] opto = 0;
  logic [15:0] sample_period, az_offset, el_offset;
  logic az_ccw, el_ccw;
  logic [2:0] drv_din;
  logic [1:0] relay, brake;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  axis_regs_spi uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .az_angle(az_angle),
    .el_angle(el_angle), .az_err(az_err), .el_err(el_err), .az_dout(az_dout),
    .el_dout(el_dout), .opto(opto), .sample_period(sample_period),
    .az_offset(az_offset), .el_offset(el_offset), .az_ccw(az_ccw),
    .el_ccw(el_ccw), .drv_din(drv_din), .relay(relay), .brake(brake));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] cmd, input logic [15:0] wd, input int nbits,
                       output logic [15:0] rd);
    logic [31:0] s;
    s = {cmd, wd, 8'h00};
    rd = '0;
    spi_cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = s[31-i];
      repeat (HALF) @(negedge clk);
      if (i >= 8 && i < 24) rd[23-i] = spi_miso;
      spi_sclk = 1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 0;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    logic [15:0] r;
    frame({1'b1, a}, d, 24, r);
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    frame({1'b0, a}, 16'h0000, 24, d);
  endtask

  task automatic pulse_err(input logic [2:0] a, input logic [2:0] e);
    az_err = a; el_err = e;
    @(negedge clk);
    az_err = 0; el_err = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] r;
    chk("R1 sample_period", sample_period, 16'd1450);
    chk("R1 az_offset", az_offset, 0);
    chk("R1 el_offset", el_offset, 0);
    rd(7'd0, r);
    chk("R1 ctrl readback", r, 0);
  endtask

  task automatic t_write;
    logic [15:0] r;
    wr(7'd1, 16'd2000);
    chk("R2 sample write", sample_period, 16'd2000);
    wr(7'd2, 16'hBEEF);
    chk("R2 az_offset write", az_offset, 16'hBEEF);
    wr(7'd3, 16'h1357);
    chk("R2 el_offset write", el_offset, 16'h1357);
    wr(7'd0, 16'h0004);
    rd(7'd0, r);
    chk("R2 R4 ctrl readback", r, 16'h0004);
    wr(7'd0, 16'h0000);
  endtask

  task automatic t_len;
    logic [15:0] r;
    frame(8'h81, 16'h0055, 23, r);
    chk("R3 23-bit frame ignored", sample_period, 16'd2000);
    frame(8'h81, 16'h0077, 25, r);
    chk("R3 25-bit frame ignored", sample_period, 16'd2000);
    frame(8'h80, 16'hFFFF, 20, r);
    rd(7'd0, r);
    chk("R3 short ctrl frame ignored", r, 16'h0000);
  endtask

  task automatic t_read;
    logic [15:0] r;
    az_angle = 16'hA5C3; el_angle = 16'h1234;
    rd(7'd2, r);
    chk("R4 az angle read", r, 16'hA5C3);
    rd(7'd3, r);
    chk("R4 el angle read", r, 16'h1234);
    opto = 2'b10; az_dout = 4'b1001; el_dout = 4'b0110;
    rd(7'd1, r);
    chk("R5 status layout", r, {2'b10, 4'b0110, 4'b1001, 6'b000000});
    opto = 2'b01;
    rd(7'd1, r);
    chk("R5 status opto0", r, {2'b01, 4'b0110, 4'b1001, 6'b000000});
    opto = 0; az_dout = 0; el_dout = 0;
  endtask

  task automatic t_unmapped;
    logic [15:0] r;
    wr(7'd5, 16'hDEAD);
    chk("R12 sample untouched", sample_period, 16'd2000);
    chk("R12 az_offset untouched", az_offset, 16'hBEEF);
    chk("R12 el_offset untouched", el_offset, 16'h1357);
    rd(7'd0, r);
    chk("R12 ctrl untouched", r, 0);
    rd(7'd5, r);
    chk("R12 unmapped read zero", r, 0);
  endtask

  task automatic t_sticky;
    logic [15:0] r;
    pulse_err(3'b010, 3'b000);
    repeat (20) @(negedge clk);
    rd(7'd1, r);
    chk("R6 az encoder sticky", r[5:0], 6'b000010);
    pulse_err(3'b000, 3'b100);
    rd(7'd1, r);
    chk("R6 el conversion sticky", r[5:0], 6'b100010);
  endtask

  task automatic t_clear;
    logic [15:0] r;
    wr(7'd0, 16'h0100);
    rd(7'd1, r);
    chk("R7 clear while set", r[5:0], 0);
    pulse_err(3'b001, 3'b000);
    rd(7'd1, r);
    chk("R7 no latch while clear set", r[5:0], 0);
    wr(7'd0, 16'h0000);
    pulse_err(3'b001, 3'b001);
    rd(7'd1, r);
    chk("R7 latch after clear released", r[5:0], 6'b001001);
  endtask

  task automatic t_auto;
    logic [15:0] r;
    pulse_err(3'b111, 3'b111);
    az_angle = 16'h0000; el_angle = 16'h4000;
    repeat (4) @(negedge clk);
    rd(7'd1, r);
    chk("R8 no autoclear while disabled", r[5:0], 6'b111111);
    wr(7'd0, 16'h0200);
    rd(7'd1, r);
    chk("R8 autoclear only zero axis", r[5:0], 6'b111000);
    az_angle = 16'h0101; wr(7'd0, 16'h0000);
  endtask

  task automatic t_relay;
    az_dout = 4'b0010; el_dout = 4'b0000;
    repeat (2) @(negedge clk);
    chk("R9 relay follows drive out2", relay, 2'b01);
    wr(7'd0, 16'h8004);
    chk("R9 relay from ctrl bits", relay, 2'b10);
    wr(7'd0, 16'h4004);
    chk("R9 relay0 from bit14", relay, 2'b01);
    wr(7'd0, 16'h0000);
    el_dout = 4'b0010; az_dout = 0;
    repeat (2) @(negedge clk);
    chk("R9 relay1 follows el out2", relay, 2'b10);
    el_dout = 0;
  endtask

  task automatic t_brake;
    az_dout = 4'b0001; el_dout = 4'b0000;
    repeat (2) @(negedge clk);
    chk("R10 brake follows drive out1", brake, 2'b01);
    wr(7'd0, 16'h0018);
    chk("R10 brake from bit3", brake, 2'b11);
    wr(7'd0, 16'h0010);
    chk("R10 brake off from bit3", brake, 2'b00);
    wr(7'd0, 16'h0000);
    az_dout = 0; el_dout = 4'b0001;
    repeat (2) @(negedge clk);
    chk("R10 brake1 follows el out1", brake, 2'b10);
    el_dout = 0;
  endtask

  task automatic t_din;
    wr(7'd0, 16'h28A0);
    chk("R11 drive inputs 7..5", drv_din, 3'b101);
    chk("R11 az direction", az_ccw, 1'b1);
    chk("R11 el direction", el_ccw, 1'b1);
    wr(7'd0, 16'h0840);
    chk("R11 drive inputs second", drv_din, 3'b010);
    chk("R11 el direction off", {az_ccw, el_ccw}, 2'b10);
    wr(7'd0, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset;
    t_write;
    t_len;
    t_read;
    t_unmapped;
    t_sticky;
    t_clear;
    t_auto;
    t_relay;
    t_brake;
    t_din;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule